// File: doc/BRIEF.md
# Multi-Line Receive Queue

This block gathers received characters from several serial receivers into one shared first-in first-out queue, so that a host can service every line through a single 16-bit read port. Each receiver presents a one-cycle strobe with a character and two error flags: parity and framing. Every line has a one-deep holding stage. A fixed-priority arbiter moves the held characters into the queue one per cycle, lowest line number first. Each stored entry records the character, the number of the line it came from, its error flags and an overrun mark.

The host sees the oldest entry as a head word that changes with the queue state. Bit 15 of that word tells whether the entry is real. A read strobe removes the head entry. A data-available status output and a receive interrupt, gated by an enable input, tell the host that there is work. Arrivals are accepted only while the scan enable is high. A master clear empties the queue, the holding stages and any pending overrun mark in one cycle. When a character is lost because there is no room for it, the next entry that is written carries the overrun mark.

Top module: `rx_silo`

## Requirements
- R1: The queue holds exactly DEPTH (default 64) entries. A character that reaches the queue while all entries are occupied is discarded, and the entries already stored are kept unchanged.
- R2: The head word carries the character in bits 7:0 and the source line number (0 to 3) in bits 9:8. Bits 11:10 are always zero.
- R3: Bit 12 of an entry is set when its character arrived with the parity-error flag, and bit 13 is set when it arrived with the framing-error flag.
- R4: Bit 15 of the head word is 1 exactly when the queue is non-empty. When the queue is empty, the whole head word reads as zero.
- R5: After a character is lost, bit 14 is set on the next entry written to the queue, and only on that entry.
- R6: Characters strobed on several lines in the same cycle enter the queue in ascending line-number order, one per cycle.
- R7: A read strobe removes the head entry, and the next entry becomes visible after that clock edge. A read strobe on an empty queue has no effect.
- R8: data_avail is high exactly when the queue is non-empty. rx_irq is high only when data_avail and irq_en are both high.
- R9: A master clear empties the queue, discards held characters and cancels a pending overrun mark. It takes priority over arrivals in the same cycle.
- R10: While scan_en is low, receive strobes are ignored.
- R11: On an empty queue, a strobed character becomes visible at the head after the second rising edge, counting the edge that samples the strobe as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Master scan enable; arrivals are accepted only while this is high |
| clear | input | 1 | Synchronous master clear |
| irq_en | input | 1 | Receive interrupt enable |
| line_vld | input | 4 | Per-line character strobe |
| line_char | input | 32 | Per-line character, line n in bits 8n+7:8n |
| line_perr | input | 4 | Per-line parity-error flag |
| line_ferr | input | 4 | Per-line framing-error flag |
| rd_pop | input | 1 | Read strobe; removes the head entry |
| head_word | output | 16 | Head entry of the queue |
| data_avail | output | 1 | Queue is non-empty |
| rx_irq | output | 1 | Receive interrupt |

## Verification
Two operations can fall in the same clock edge: the arbiter writes a held character into the queue while the host's read strobe removes the head. The bench causes this by streaming one character per cycle on a line while it also strobes a read every cycle. The queue stays at one entry, data_avail never drops, and every head word must match the next value in the arrival order. A second collision happens at a full queue: a character is granted while no entry is free. The bench judges this case by the overrun mark that appears on the next entry written after space is freed.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;
  localparam int CHAR_W = 8;
  localparam int LINE_W = 2;

  typedef struct packed {
    logic              ovr;
    logic              ferr;
    logic              perr;
    logic [LINE_W-1:0] line;
    logic [CHAR_W-1:0] ch;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);
endpackage

// File: rtl/rx_line_hold.sv
module rx_line_hold #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          take,
  input  logic [CW-1:0] ch_in,
  input  logic          perr_in,
  input  logic          ferr_in,
  input  logic          release_i,
  output logic          full,
  output logic [CW-1:0] ch,
  output logic          perr,
  output logic          ferr,
  output logic          lost
);
  logic          full_q, full_d;
  logic [CW-1:0] ch_q, ch_d;
  logic          perr_q, perr_d, ferr_q, ferr_d;
  logic          accept;

  assign accept = take && (!full_q || release_i);
  assign lost   = take && full_q && !release_i && !clear;

  always_comb begin
    full_d = full_q;
    ch_d   = ch_q;
    perr_d = perr_q;
    ferr_d = ferr_q;
    if (clear) begin
      full_d = 1'b0;
    end else if (accept) begin
      full_d = 1'b1;
      ch_d   = ch_in;
      perr_d = perr_in;
      ferr_d = ferr_in;
    end else if (release_i) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ch_q   <= '0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      full_q <= full_d;
      ch_q   <= ch_d;
      perr_q <= perr_d;
      ferr_q <= ferr_d;
    end
  end

  assign full = full_q;
  assign ch   = ch_q;
  assign perr = perr_q;
  assign ferr = ferr_q;
endmodule

// File: rtl/rx_line_arb.sv
module rx_line_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        grant[i] = 1'b1;
        idx      = IW'(i);
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_silo_fifo.sv
module rx_silo_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 13,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop_req,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic          accepted
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_pop;

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CW'(DEPTH));
  assign accepted = push && !full && !clear;
  assign do_pop   = pop_req && !empty && !clear;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (clear) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (accepted) wr_d = wr_q + 1'b1;
      if (do_pop)   rd_d = rd_q + 1'b1;
      case ({accepted, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accepted) mem[wr_q] <= din;
  end

  assign dout = mem[rd_q];
endmodule

// File: rtl/rx_silo.sv
module rx_silo #(
  parameter int NUM_LINES = 4,
  parameter int DEPTH     = 64,
  localparam int CW       = rx_silo_pkg::CHAR_W,
  localparam int LW       = rx_silo_pkg::LINE_W,
  localparam int IW       = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scan_en,
  input  logic                      clear,
  input  logic                      irq_en,
  input  logic [NUM_LINES-1:0]      line_vld,
  input  logic [NUM_LINES*CW-1:0]   line_char,
  input  logic [NUM_LINES-1:0]      line_perr,
  input  logic [NUM_LINES-1:0]      line_ferr,
  input  logic                      rd_pop,
  output logic [15:0]               head_word,
  output logic                      data_avail,
  output logic                      rx_irq
);
  import rx_silo_pkg::*;

  logic [NUM_LINES-1:0] h_full, h_perr, h_ferr, h_lost, grant;
  logic [CW-1:0]        h_ch [NUM_LINES];
  logic [IW-1:0]        g_idx;
  logic                 g_any;
  rx_entry_t            w_entry, r_entry;
  logic [ENTRY_W-1:0]   r_bits;
  logic                 f_empty, f_full, f_acc;
  logic                 ovr_q, ovr_d;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_hold
    rx_line_hold #(.CW(CW)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear),
      .take      (line_vld[g] && scan_en),
      .ch_in     (line_char[g*CW +: CW]),
      .perr_in   (line_perr[g]),
      .ferr_in   (line_ferr[g]),
      .release_i (grant[g]),
      .full      (h_full[g]),
      .ch        (h_ch[g]),
      .perr      (h_perr[g]),
      .ferr      (h_ferr[g]),
      .lost      (h_lost[g])
    );
  end

  rx_line_arb #(.N(NUM_LINES)) u_arb (
    .req   (h_full),
    .grant (grant),
    .idx   (g_idx),
    .any   (g_any)
  );

  always_comb begin
    w_entry      = '0;
    w_entry.ch   = h_ch[g_idx];
    w_entry.line = LW'(g_idx);
    w_entry.perr = h_perr[g_idx];
    w_entry.ferr = h_ferr[g_idx];
    w_entry.ovr  = ovr_q;
  end

  rx_silo_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .push     (g_any),
    .din      (w_entry),
    .pop_req  (rd_pop),
    .dout     (r_bits),
    .empty    (f_empty),
    .full     (f_full),
    .accepted (f_acc)
  );

  always_comb begin
    ovr_d = ovr_q;
    if (clear) begin
      ovr_d = 1'b0;
    end else begin
      if (f_acc) ovr_d = 1'b0;
      if ((g_any && f_full) || (|h_lost)) ovr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  assign r_entry    = rx_entry_t'(r_bits);
  assign data_avail = !f_empty;
  assign rx_irq     = data_avail && irq_en;
  assign head_word  = f_empty ? 16'h0000 :
                      {1'b1, r_entry.ovr, r_entry.ferr, r_entry.perr,
                       2'b00, r_entry.line, r_entry.ch};
endmodule

// File: rtl/rx_silo_chk.sv
module rx_silo_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clear,
  input logic        irq_en,
  input logic        data_avail,
  input logic        rx_irq,
  input logic [15:0] head_word
);
  p_zero_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    head_word[11:10] == 2'b00);

  p_empty_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !data_avail |-> head_word == 16'h0000);

  p_valid_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_avail |-> head_word[15]);

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !rx_irq);

  p_irq_needs_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> data_avail);

  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !data_avail);
endmodule

bind rx_silo rx_silo_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clear      (clear),
  .irq_en     (irq_en),
  .data_avail (data_avail),
  .rx_irq     (rx_irq),
  .head_word  (head_word)
);

// File: tb/rx_silo_test.sv
module rx_silo_test;
  localparam int PERIOD = 10;

  logic        clk, rst_n, scan_en, clear, irq_en, rd_pop;
  logic [3:0]  line_vld, line_perr, line_ferr;
  logic [31:0] line_char;
  logic [15:0] head_word;
  logic        data_avail, rx_irq;
  int          checks, errors;

  rx_silo uut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .clear(clear),
    .irq_en(irq_en), .line_vld(line_vld), .line_char(line_char),
    .line_perr(line_perr), .line_ferr(line_ferr), .rd_pop(rd_pop),
    .head_word(head_word), .data_avail(data_avail), .rx_irq(rx_irq)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] word(input int ln, input logic [7:0] c,
                                       input logic pe, input logic fe, input logic ov);
    return {1'b1, ov, fe, pe, 2'b00, 2'(ln), c};
  endfunction

  task automatic idle();
    line_vld = '0; line_char = '0; line_perr = '0; line_ferr = '0;
    rd_pop = 1'b0; clear = 1'b0;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input int ln, input logic [7:0] c, input logic pe, input logic fe);
    line_vld[ln] = 1'b1;
    line_char[ln*8 +: 8] = c;
    line_perr[ln] = pe;
    line_ferr[ln] = fe;
    @(negedge clk);
    idle();
  endtask

  task automatic pop();
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic t_reset();
    chk("R4 reset word", head_word, 16'h0000);
    chk("R8 reset avail", {15'd0, data_avail}, 16'd0);
    chk("R8 reset irq", {15'd0, rx_irq}, 16'd0);
  endtask

  task automatic t_single();
    send(1, 8'h5A, 1'b0, 1'b0);
    chk("R11 not yet visible", {15'd0, data_avail}, 16'd0);
    cycles(1);
    chk("R11 R2 head after two edges", head_word, word(1, 8'h5A, 0, 0, 0));
    chk("R8 avail", {15'd0, data_avail}, 16'd1);
    pop();
    chk("R7 popped to empty", head_word, 16'h0000);
    pop();
    chk("R7 pop on empty", head_word, 16'h0000);
    send(3, 8'hC3, 1'b0, 1'b0);
    cycles(1);
    chk("R7 R2 after empty pop", head_word, word(3, 8'hC3, 0, 0, 0));
    pop();
  endtask

  task automatic t_errors();
    send(2, 8'h11, 1'b1, 1'b0);
    send(3, 8'h22, 1'b0, 1'b1);
    cycles(1);
    chk("R3 parity flag", head_word, word(2, 8'h11, 1, 0, 0));
    pop();
    chk("R3 framing flag", head_word, word(3, 8'h22, 0, 1, 0));
    pop();
  endtask

  task automatic t_simul();
    line_vld = 4'b1111;
    line_char = {8'hD3, 8'hC2, 8'hB1, 8'hA0};
    @(negedge clk);
    idle();
    cycles(4);
    for (int ln = 0; ln < 4; ln++) begin
      chk("R6 ascending order", head_word, word(ln, 8'hA0 + 8'(ln * 17), 0, 0, 0));
      pop();
    end
    chk("R6 drained", head_word, 16'h0000);
  endtask

  task automatic t_stream();
    send(1, 8'h10, 0, 0);
    send(1, 8'h11, 0, 0);
    cycles(1);
    for (int k = 0; k < 8; k++) begin
      logic [7:0] e;
      e = (k == 0) ? 8'h10 : (k == 1) ? 8'h11 : 8'(8'h20 + k - 2);
      chk("R7 push with pop", head_word, word(1, e, 0, 0, 0));
      chk("R8 avail kept", {15'd0, data_avail}, 16'd1);
      line_vld[1] = 1'b1;
      line_char[15:8] = 8'(8'h20 + k);
      rd_pop = 1'b1;
      @(negedge clk);
      idle();
    end
    cycles(1);
    chk("R7 stream tail a", head_word, word(1, 8'h26, 0, 0, 0));
    pop();
    chk("R7 stream tail b", head_word, word(1, 8'h27, 0, 0, 0));
    pop();
    chk("R7 stream empty", head_word, 16'h0000);
  endtask

  task automatic fill65();
    for (int i = 0; i < 65; i++) begin
      line_vld[0] = 1'b1;
      line_char[7:0] = 8'(i);
      @(negedge clk);
    end
    idle();
    cycles(2);
  endtask

  task automatic t_overrun();
    fill65();
    chk("R1 full head", head_word, word(0, 8'h00, 0, 0, 0));
    pop();
    send(2, 8'hAA, 0, 0);
    cycles(1);
    for (int i = 1; i < 64; i++) begin
      chk("R1 R5 kept entry", head_word, word(0, 8'(i), 0, 0, 0));
      pop();
    end
    chk("R5 overrun mark", head_word, word(2, 8'hAA, 0, 0, 1));
    pop();
    chk("R1 dropped char absent", head_word, 16'h0000);
    send(2, 8'hAB, 0, 0);
    cycles(1);
    chk("R5 mark only once", head_word, word(2, 8'hAB, 0, 0, 0));
    pop();
  endtask

  task automatic t_scan();
    scan_en = 1'b0;
    send(0, 8'h77, 0, 0);
    cycles(3);
    chk("R10 ignored", head_word, 16'h0000);
    scan_en = 1'b1;
    cycles(2);
    chk("R10 not captured", head_word, 16'h0000);
  endtask

  task automatic t_clear();
    fill65();
    line_vld = 4'b0110;
    line_char = 32'h0033_4400;
    clear = 1'b1;
    @(negedge clk);
    idle();
    chk("R9 emptied", head_word, 16'h0000);
    cycles(2);
    chk("R9 held chars dropped", head_word, 16'h0000);
    send(1, 8'h99, 0, 0);
    cycles(1);
    chk("R9 overrun cancelled", head_word, word(1, 8'h99, 0, 0, 0));
    pop();
  endtask

  task automatic t_irq();
    irq_en = 1'b0;
    send(0, 8'h01, 0, 0);
    cycles(1);
    chk("R8 irq masked", {15'd0, rx_irq}, 16'd0);
    irq_en = 1'b1;
    #1;
    chk("R8 irq raised", {15'd0, rx_irq}, 16'd1);
    pop();
    chk("R8 irq after drain", {15'd0, rx_irq}, 16'd0);
    irq_en = 1'b0;
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; scan_en = 1'b1; irq_en = 1'b0;
    idle();
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    t_reset();
    t_single();
    t_errors();
    t_simul();
    t_stream();
    t_overrun();
    t_scan();
    t_clear();
    t_irq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule